// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Stage Start Check

This block receives asynchronous serial frames on a single input line. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The line is first brought into the clock domain by a two-flip-flop synchronizer. A falling edge alone does not start a frame. It starts a tick counter, and the start bit is accepted only if the line is still low when that counter reaches a programmable compare value. A short low glitch is therefore rejected and the receiver goes back to waiting.

Bit timing comes from an oversampling tick input, sixteen ticks per bit. After an accepted start, each following bit is sampled once, exactly sixteen ticks after the previous sample. A completed frame raises a one-cycle completion pulse. In the same clock edge the byte is written to the receive-data output. Parity and framing errors set sticky flags but never cut a frame short. If the previous byte is still unread when a frame completes, the overrun flag is set and the old byte is kept. A read strobe from the consumer marks the byte as taken and clears the error flags.

Top module: `serial_rx_unit`

## Requirements
- R1: Reception takes place only while both `pwr_en` and `rx_en` are 1. While either is 0, line activity produces no completion pulse and leaves `rx_data` unchanged.
- R2: A falling edge on the synchronized line starts a counter that advances on each `os_tick`. At the tick where the counter equals `start_cmp`, the line is sampled. If it is high, the frame is rejected and the receiver returns to waiting with no completion pulse.
- R3: After an accepted start, eight data bits are assembled least significant bit first. The first data bit received lands in `rx_data[0]`.
- R4: On the stop-bit sample, `rx_irq` is high for exactly one clock. `rx_data` takes the new byte on that same edge, unless an overrun occurs (R7).
- R5: When `par_en` is 1, one parity bit follows the data bits. `par_odd` = 0 selects even parity and 1 selects odd parity. A mismatch sets `err_parity`, and the byte is still delivered. When `par_en` is 0, the stop bit directly follows the eighth data bit.
- R6: A stop-bit sample of 0 sets `err_frame`. The frame still completes, with the completion pulse and the data write.
- R7: If a frame completes while the previous byte is unread, `err_overrun` is set and `rx_data` keeps the old byte. The completion pulse still fires.
- R8: A one-cycle `rd_stb` marks the byte as read and clears `err_parity`, `err_frame` and `err_overrun`. The next frame then completes without overrun.
- R9: Error flags are sticky. A later error-free frame does not clear them; only a read or R10 does.
- R10: Dropping `rx_en` or `pwr_en` aborts a frame in progress and returns the receiver to waiting. Dropping `pwr_en` also clears all error flags and the unread state.
- R11: Only one stop bit is checked. Additional high bits after the stop bit are treated as idle line, and the next start is still detected.
- R12: Every data, parity and stop bit is sampled 16 `os_tick` pulses after the previous sample. Reception therefore follows the tick rate, not the clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Receiver power enable; low clears status |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present in frame |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| start_cmp | input | 8 | Tick count from falling edge to start recheck |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| rd_stb | input | 1 | Consumer has read `rx_data` |
| rx_data | output | 8 | Receive-data register |
| rx_irq | output | 1 | One-cycle frame completion pulse |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default parameters: 8 data bits, 16 ticks per bit and a two-stage synchronizer. `start_cmp` is set to 7, so the start recheck falls near mid-bit. A four-cycle low pulse is short enough to reach the recheck while high, which exercises the rejection path. Most frames run with a tick on every clock, which keeps each frame short, so overrun, sticky flags and abort sequences fit in one run. One frame runs with a tick every third clock to show that sampling follows the tick and not the clock.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sh   = {q.sh[STAGES-2:0], line_in};
        d.prev = q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign line_s = q.sh[STAGES-1];
    assign fall   = q.prev & ~q.sh[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              os_tick,
    input  logic              line_s,
    input  logic              fall,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              frm_done,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_perr,
    output logic              frm_ferr
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  bidx;
        logic [DATA_W-1:0] sh;
        logic              pbit;
    } eng_t;

    eng_t q, d;
    logic bit_pt;

    assign bit_pt = os_tick && (q.cnt == BIT_LAST);

    always_comb begin
        d        = q;
        frm_done = 1'b0;
        if (!armed) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else begin
            if (os_tick && q.st != ST_IDLE && q.st != ST_START)
                d.cnt = bit_pt ? '0 : q.cnt + 1'b1;
            case (q.st)
                ST_IDLE: if (fall) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
                ST_START: if (os_tick) begin
                    if (q.cnt == cmp) begin
                        d.cnt  = '0;
                        d.bidx = '0;
                        d.st   = line_s ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: if (bit_pt) begin
                    d.sh = {line_s, q.sh[DATA_W-1:1]};
                    if (q.bidx == IDX_LAST) d.st = par_en ? ST_PAR : ST_STOP;
                    else                    d.bidx = q.bidx + 1'b1;
                end
                ST_PAR: if (bit_pt) begin
                    d.pbit = line_s;
                    d.st   = ST_STOP;
                end
                ST_STOP: if (bit_pt) begin
                    frm_done = 1'b1;
                    d.st     = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign frm_data = q.sh;
    assign frm_ferr = ~line_s;
    assign frm_perr = par_en & (^q.sh ^ q.pbit ^ par_odd);

    p_reject_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && q.st == ST_START && os_tick && q.cnt == cmp && line_s |=> q.st == ST_IDLE);
    p_disarm_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> q.st == ST_IDLE && !frm_done);
    p_cnt_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_DATA || q.st == ST_PAR || q.st == ST_STOP |-> q.cnt <= BIT_LAST);
    p_no_idle_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_IDLE |-> !frm_done);
endmodule

// File: rtl/rx_hold_regs.sv
module rx_hold_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              frm_done,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_perr,
    input  logic              frm_ferr,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_irq,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              perr;
        logic              ferr;
        logic              ovr;
        logic              irq;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d     = q;
        d.irq = frm_done;
        if (rd_stb) begin
            d.full = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
            d.ovr  = 1'b0;
        end
        if (frm_done) begin
            d.perr = d.perr | frm_perr;
            d.ferr = d.ferr | frm_ferr;
            if (d.full) begin
                d.ovr = 1'b1;
            end else begin
                d.data = frm_data;
                d.full = 1'b1;
            end
        end
        if (!pwr_en) begin
            d.full = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
            d.ovr  = 1'b0;
            d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data     = q.data;
    assign rx_irq      = q.irq;
    assign err_parity  = q.perr;
    assign err_frame   = q.ferr;
    assign err_overrun = q.ovr;

    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    p_irq_with_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && pwr_en && !q.full |=> rx_irq && rx_data == $past(frm_data));
    p_ovr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && pwr_en && q.full && !rd_stb |=> $stable(rx_data) && err_overrun);
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !frm_done |=> !err_overrun && !err_parity && !err_frame);
    p_pwr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !err_overrun && !err_parity && !err_frame && !rx_irq);
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [CNT_W-1:0]  start_cmp,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_irq,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);
    logic              line_s, fall, armed;
    logic              frm_done, frm_perr, frm_ferr;
    logic [DATA_W-1:0] frm_data;

    assign armed = pwr_en & rx_en;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(rx_line),
        .line_s(line_s), .fall(fall)
    );

    rx_frame_engine #(.DATA_W(DATA_W), .OSR(OSR), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .armed(armed), .os_tick(os_tick),
        .line_s(line_s), .fall(fall), .cmp(start_cmp),
        .par_en(par_en), .par_odd(par_odd),
        .frm_done(frm_done), .frm_data(frm_data),
        .frm_perr(frm_perr), .frm_ferr(frm_ferr)
    );

    rx_hold_regs #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
        .frm_done(frm_done), .frm_data(frm_data),
        .frm_perr(frm_perr), .frm_ferr(frm_ferr), .rd_stb(rd_stb),
        .rx_data(rx_data), .rx_irq(rx_irq), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun)
    );
endmodule

// File: tb/sim_serial_rx_unit.sv
module sim_serial_rx_unit;
    logic       clk = 1'b0;
    logic       rst_n, pwr_en, rx_en, par_en, par_odd, os_tick, rx_line, rd_stb;
    logic [7:0] start_cmp, rx_data;
    logic       rx_irq, err_parity, err_frame, err_overrun;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int div = 1;
    int tcnt = 0;

    always #5 clk = ~clk;

    serial_rx_unit u0 (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .start_cmp(start_cmp),
        .os_tick(os_tick), .rx_line(rx_line), .rd_stb(rd_stb),
        .rx_data(rx_data), .rx_irq(rx_irq), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun)
    );

    always @(negedge clk) begin
        if (tcnt >= div - 1) begin
            os_tick <= 1'b1;
            tcnt    <= 0;
        end else begin
            os_tick <= 1'b0;
            tcnt    <= tcnt + 1;
        end
        if (rx_irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_line = v;
        repeat (16 * div) @(negedge clk);
    endtask

    // pmode: 0 no parity bit, 1 correct parity, 2 wrong parity
    task automatic send(input logic [7:0] b, input int pmode, input logic stopv, input int nstop);
        logic p;
        p = ^b ^ par_odd;
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        if (pmode == 1) hold_bit(p);
        if (pmode == 2) hold_bit(~p);
        hold_bit(stopv);
        for (int i = 1; i < nstop; i++) hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("reset rx_data", rx_data, 0);
        chk("reset flags", {err_parity, err_frame, err_overrun, rx_irq}, 0);
    endtask

    task automatic t_disarmed();
        int n0;
        n0 = irq_cnt;
        pwr_en = 1'b1; rx_en = 1'b0;
        send(8'h5A, 0, 1'b1, 1);
        pwr_en = 1'b0; rx_en = 1'b1;
        send(8'h5A, 0, 1'b1, 1);
        chk("R1 no irq while disarmed", irq_cnt - n0, 0);
        chk("R1 rx_data unchanged", rx_data, 0);
        pwr_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        int n0;
        n0 = irq_cnt;
        send(8'hC1, 0, 1'b1, 1);
        chk("R3 LSB-first byte C1", rx_data, 8'hC1);
        chk("R4 one completion pulse", irq_cnt - n0, 1);
        chk("R4 no error flags", {err_parity, err_frame, err_overrun}, 0);
        do_read();
        send(8'h6B, 0, 1'b1, 1);
        chk("R3 LSB-first byte 6B", rx_data, 8'h6B);
        do_read();
    endtask

    task automatic t_glitch();
        int n0;
        n0 = irq_cnt;
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
        chk("R2 glitch gives no irq", irq_cnt - n0, 0);
        chk("R2 glitch leaves data", rx_data, 8'h6B);
        send(8'h2D, 0, 1'b1, 1);
        chk("R2 frame after glitch", rx_data, 8'h2D);
        do_read();
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h71, 1, 1'b1, 1);
        chk("R5 even parity ok data", rx_data, 8'h71);
        chk("R5 even parity ok flag", err_parity, 0);
        do_read();
        send(8'h71, 2, 1'b1, 1);
        chk("R5 even parity bad flag", err_parity, 1);
        do_read();
        par_odd = 1'b1;
        send(8'h0F, 1, 1'b1, 1);
        chk("R5 odd parity ok flag", err_parity, 0);
        chk("R5 odd parity data", rx_data, 8'h0F);
        do_read();
        send(8'h0E, 2, 1'b1, 1);
        chk("R5 odd parity bad flag", err_parity, 1);
        chk("R5 data kept on parity error", rx_data, 8'h0E);
        do_read();
        chk("R8 read clears parity flag", err_parity, 0);
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_frame_overrun();
        int n0;
        n0 = irq_cnt;
        send(8'h93, 0, 1'b0, 1);
        chk("R6 framing flag", err_frame, 1);
        chk("R6 data written", rx_data, 8'h93);
        chk("R6 irq fires", irq_cnt - n0, 1);
        send(8'h44, 0, 1'b1, 1);
        chk("R7 overrun flag", err_overrun, 1);
        chk("R7 old data kept", rx_data, 8'h93);
        chk("R7 irq still fires", irq_cnt - n0, 2);
        chk("R9 framing flag sticky", err_frame, 1);
        do_read();
        chk("R8 read clears flags", {err_parity, err_frame, err_overrun}, 0);
        send(8'h44, 0, 1'b1, 1);
        chk("R8 no overrun after read", err_overrun, 0);
        chk("R8 new data after read", rx_data, 8'h44);
        do_read();
    endtask

    task automatic t_two_stop();
        send(8'hA6, 0, 1'b1, 2);
        chk("R11 two stop bits data", rx_data, 8'hA6);
        chk("R11 no framing error", err_frame, 0);
        do_read();
        send(8'h3B, 0, 1'b1, 2);
        chk("R11 next start detected", rx_data, 8'h3B);
        do_read();
    endtask

    task automatic t_abort();
        int n0;
        n0 = irq_cnt;
        fork
            send(8'h81, 0, 1'b1, 1);
            begin
                repeat (60) @(negedge clk);
                rx_en = 1'b0;
            end
        join
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 aborted frame no irq", irq_cnt - n0, 0);
        chk("R10 aborted frame data kept", rx_data, 8'h3B);
        send(8'h55, 0, 1'b0, 1);
        chk("R10 framing set before power-off", err_frame, 1);
        pwr_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 power-off clears flags", {err_parity, err_frame, err_overrun}, 0);
        pwr_en = 1'b1;
        @(negedge clk);
        send(8'h66, 0, 1'b1, 1);
        chk("R10 unread state cleared", {err_overrun, rx_data}, 8'h66);
        do_read();
    endtask

    task automatic t_slow_tick();
        div = 3;
        repeat (4) @(negedge clk);
        send(8'hD2, 0, 1'b1, 1);
        chk("R12 slow tick data", rx_data, 8'hD2);
        chk("R12 slow tick no flags", {err_parity, err_frame, err_overrun}, 0);
        do_read();
        div = 1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; pwr_en = 1'b0; rx_en = 1'b0; par_en = 1'b0; par_odd = 1'b0;
        start_cmp = 8'd7; rx_line = 1'b1; rd_stb = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_disarmed();
        t_basic();
        t_glitch();
        t_parity();
        t_frame_overrun();
        t_two_stop();
        t_abort();
        t_slow_tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule